// File: doc/BRIEF.md
# Flash Page-Mode Read Datapath

This block is a synthesizable read-side model of a NOR flash. It holds a small word array and gives read access to it in one of two modes. In the asynchronous page mode, one access reads all four words of a page into a buffer. The low two address bits then pick words out of that buffer at once, with no new access delay. In the synchronous burst mode, a start address is taken on a clock edge. After a fixed latency, during which the wait output is high, the block returns one word per clock from consecutive addresses.

A one-bit mode register chooses between the two modes. After reset the block is in page mode. A read runs only while chip enable is low and write enable is high. The address valid strobe controls how the address is taken. In page mode it acts as a level-sensitive latch. In burst mode it acts as a clocked start strobe.

Top module: `flash_page_read`

## Requirements
- R1: After reset the block is in page mode, and valid_o, wait_o, dq_oe_o and dq_o are all zero.
- R2: A clock edge with cfg_wr_i high loads cfg_async_i into the mode bit (1 = page mode, 0 = burst mode). The same edge aborts any access in progress, so valid_o and wait_o are low afterwards.
- R3: A read is active only while ce_ni is 0 and we_ni is 1. Otherwise dq_oe_o, valid_o and wait_o are 0 and dq_o is zero.
- R4: In page mode wait_o is never asserted.
- R5: In page mode, a page miss forces valid_o low at once. A miss is either the first read after an idle period or a change of the page address (addr_i[ADDR_W-1:2]). The page is then sensed at the next rising edge. valid_o rises after the ACC_LAT-th rising edge counted from that one, with dq_o holding that page's word, and dq_o stays zero until then.
- R6: While valid_o is high in page mode, a change of addr_i[1:0] alone changes dq_o to the selected buffered word in the same cycle, and valid_o stays high.
- R7: In page mode, while adv_ni is low the page address follows addr_i. While adv_ni is high the page taken at the last rising edge with adv_ni low is held, and upper address changes are ignored.
- R8: In burst mode, a rising edge with adv_ni low takes addr_i as the start address. wait_o is then high and valid_o low for BURST_LAT cycles. After that, valid_o is high and dq_o gives the start word, and each later edge advances the address by one, wrapping from the top of the array to word 0.
- R9: The word stored at address a is (16'h5A00 + 7*a) mod 2^16.
- R10: In burst mode, adv_ni low at an edge during a burst restarts it from the new address with the full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for sensing, latency and burst stepping |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; must be high to read |
| adv_ni | input | 1 | Address valid strobe, active low |
| addr_i | input | ADDR_W | Word address |
| cfg_wr_i | input | 1 | Mode register write strobe |
| cfg_async_i | input | 1 | Mode value: 1 page mode, 0 burst mode |
| dq_o | output | 16 | Read data, zero when not valid |
| dq_oe_o | output | 1 | Data bus drive enable |
| valid_o | output | 1 | Read data valid |
| wait_o | output | 1 | Burst latency indicator |

## Verification
The bench uses the default parameters: ADDR_W=6 (64 words in 16 pages), ACC_LAT=3 and BURST_LAT=2. With a 64-word array, a burst started at address 62 crosses a page boundary and then wraps from 63 to 0 within four words. The latency of three cycles makes the invalid window long enough to check at more than one edge. The vector table covers several pages, including the first and the last.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int WORD_W     = 16;
  localparam int PAGE_WORDS = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    BST_IDLE,
    BST_LAT,
    BST_DATA
  } bst_state_e;

  // preload pattern of the array
  function automatic word_t fill_word(input int unsigned idx);
    return word_t'(32'h0000_5A00 + idx * 32'd7);
  endfunction
endpackage

// File: rtl/fpr_array.sv
module fpr_array
  import fpr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [ADDR_W-3:0]                    page_idx_i,
  input  logic [ADDR_W-1:0]                    word_addr_i,
  output logic [PAGE_WORDS-1:0][WORD_W-1:0]    page_o,
  output word_t                                word_o
);
  localparam int DEPTH = 1 << ADDR_W;

  word_t mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= fill_word(g);
      else         mem_q[g] <= mem_q[g];
    end
  end

  for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_page
    assign page_o[w] = mem_q[{page_idx_i, 2'(w)}];
  end

  assign word_o = mem_q[word_addr_i];
endmodule

// File: rtl/fpr_page_ctrl.sv
module fpr_page_ctrl
  import fpr_pkg::*;
#(
  parameter int PAGE_W  = 4,
  parameter int ACC_LAT = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              en_i,
  input  logic                              clr_i,
  input  logic [PAGE_W-1:0]                 page_i,
  input  logic [PAGE_WORDS-1:0][WORD_W-1:0] page_data_i,
  input  logic [1:0]                        wsel_i,
  output logic                              valid_o,
  output word_t                             word_o
);
  localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;

  logic                              vld_q;
  logic [PAGE_W-1:0]                 tag_q;
  logic [PAGE_WORDS-1:0][WORD_W-1:0] buf_q;
  logic [CNT_W-1:0]                  cnt_q;
  logic                              miss;

  assign miss = !vld_q || (tag_q != page_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      buf_q <= '0;
      cnt_q <= '0;
    end else if (clr_i || !en_i) begin
      vld_q <= 1'b0;
      cnt_q <= '0;
    end else if (miss) begin
      // sense the whole page in one access
      vld_q <= 1'b1;
      tag_q <= page_i;
      buf_q <= page_data_i;
      cnt_q <= CNT_W'(ACC_LAT - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign valid_o = en_i && !miss && (cnt_q == '0);
  assign word_o  = buf_q[wsel_i];

  if (ACC_LAT > 1) begin : g_ast_lat
    AST_SENSE_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !clr_i && miss) |=> !valid_o); // R5
  end

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !miss && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R5
endmodule

// File: rtl/fpr_burst_ctrl.sv
module fpr_burst_ctrl
  import fpr_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BURST_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              adv_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wait_o,
  output logic              valid_o
);
  localparam int CNT_W = (BURST_LAT > 1) ? $clog2(BURST_LAT) : 1;

  bst_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] baddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BST_IDLE;
      cnt_q   <= '0;
      baddr_q <= '0;
    end else if (clr_i || !en_i) begin
      state_q <= BST_IDLE;
      cnt_q   <= '0;
    end else if (!adv_ni) begin
      state_q <= BST_LAT;
      cnt_q   <= CNT_W'(BURST_LAT - 1);
      baddr_q <= addr_i;
    end else begin
      unique case (state_q)
        BST_LAT: begin
          if (cnt_q == '0) state_q <= BST_DATA;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        BST_DATA: baddr_q <= baddr_q + 1'b1; // linear, wraps at array top
        default: ;
      endcase
    end
  end

  assign addr_o  = baddr_q;
  assign wait_o  = en_i && (state_q == BST_LAT);
  assign valid_o = en_i && (state_q == BST_DATA);

  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && adv_ni && state_q == BST_DATA) |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1))); // R8

  AST_NO_SKIP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BST_IDLE) |=> (state_q != BST_DATA)); // R8
endmodule

// File: rtl/flash_page_read.sv
module flash_page_read
  import fpr_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int ACC_LAT   = 3,
  parameter int BURST_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              adv_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_async_i,
  output logic [15:0]       dq_o,
  output logic              dq_oe_o,
  output logic              valid_o,
  output logic              wait_o
);
  localparam int PAGE_W = ADDR_W - 2;

  logic                              rd_ok;
  logic                              async_q;
  logic [PAGE_W-1:0]                 page_q;
  logic [PAGE_W-1:0]                 page_eff;
  logic [PAGE_WORDS-1:0][WORD_W-1:0] arr_page;
  word_t                             arr_word;
  word_t                             pg_word;
  logic                              pg_valid;
  logic [ADDR_W-1:0]                 bst_addr;
  logic                              bst_wait;
  logic                              bst_valid;

  assign rd_ok = !ce_ni && we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       async_q <= 1'b1;
    else if (cfg_wr_i) async_q <= cfg_async_i;
  end

  // level latch of the page address: transparent while adv_ni is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      page_q <= '0;
    else if (!adv_ni) page_q <= addr_i[ADDR_W-1:2];
  end

  assign page_eff = adv_ni ? page_q : addr_i[ADDR_W-1:2];

  fpr_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .page_idx_i  (page_eff),
    .word_addr_i (bst_addr),
    .page_o      (arr_page),
    .word_o      (arr_word)
  );

  fpr_page_ctrl #(.PAGE_W(PAGE_W), .ACC_LAT(ACC_LAT)) u_page (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (rd_ok && async_q),
    .clr_i       (cfg_wr_i),
    .page_i      (page_eff),
    .page_data_i (arr_page),
    .wsel_i      (addr_i[1:0]),
    .valid_o     (pg_valid),
    .word_o      (pg_word)
  );

  fpr_burst_ctrl #(.ADDR_W(ADDR_W), .BURST_LAT(BURST_LAT)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rd_ok && !async_q),
    .clr_i   (cfg_wr_i),
    .adv_ni  (adv_ni),
    .addr_i  (addr_i),
    .addr_o  (bst_addr),
    .wait_o  (bst_wait),
    .valid_o (bst_valid)
  );

  always_comb begin
    valid_o = async_q ? pg_valid : bst_valid;
    wait_o  = !async_q && bst_wait;
    dq_oe_o = rd_ok;
    dq_o    = '0;
    if (valid_o) dq_o = async_q ? pg_word : arr_word;
  end

  AST_ASYNC_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    async_q |-> !wait_o); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || !we_ni) |-> (!valid_o && !wait_o && !dq_oe_o && dq_o == '0)); // R3

  AST_WAIT_VALID_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wait_o && valid_o)); // R8

  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(adv_ni) |-> $stable(page_q)); // R7
endmodule

// File: tb/flash_page_read_tb.sv
module flash_page_read_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int ACC_LAT    = 3;
  localparam int BURST_LAT  = 2;
  localparam int NVEC       = 8;

  localparam logic [5:0]  VEC_ADDR [NVEC] = '{6'd0, 6'd5, 6'd13, 6'd22, 6'd63, 6'd40, 6'd31, 6'd9};
  localparam logic [15:0] VEC_EXP  [NVEC] = '{16'h5A00, 16'h5A23, 16'h5A5B, 16'h5A9A,
                                              16'h5BB9, 16'h5B18, 16'h5AD9, 16'h5A3F};

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ce_ni = 1'b1;
  logic              we_ni = 1'b1;
  logic              adv_ni = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              cfg_wr = 1'b0;
  logic              cfg_async = 1'b0;
  logic [15:0]       dq;
  logic              dq_oe, valid, wt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_page_read #(.ADDR_W(ADDR_W), .ACC_LAT(ACC_LAT), .BURST_LAT(BURST_LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .adv_ni(adv_ni),
    .addr_i(addr), .cfg_wr_i(cfg_wr), .cfg_async_i(cfg_async),
    .dq_o(dq), .dq_oe_o(dq_oe), .valid_o(valid), .wait_o(wt)
  );

  function automatic logic [15:0] word_at(input int a);
    return 16'(32'h5A00 + 7 * (a % 64));
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic edge_drive; @(posedge clk); #1; endtask
  task automatic edge_sample; @(posedge clk); #4; endtask

  initial begin
    #(CLK_PERIOD * 2 + 2);
    chk("R1", "valid in reset", 16'(valid), 16'h0);
    chk("R1", "wait in reset", 16'(wt), 16'h0);
    chk("R1", "dq in reset", dq, 16'h0);
    chk("R1", "oe in reset", 16'(dq_oe), 16'h0);
    edge_drive();
    rst_ni = 1'b1;

    // table walk: page reads in the reset mode (R1, R5, R9, R4)
    for (int i = 0; i < NVEC; i++) begin
      edge_drive();
      ce_ni = 1'b1; adv_ni = 1'b1;
      edge_drive();
      ce_ni = 1'b0; adv_ni = 1'b0; addr = VEC_ADDR[i];
      #3;
      chk("R5", "valid before sense", 16'(valid), 16'h0);
      for (int k = 0; k < ACC_LAT - 1; k++) begin
        edge_sample();
        chk("R5", "valid during delay", 16'(valid), 16'h0);
        chk("R5", "dq during delay", dq, 16'h0);
        chk("R4", "wait in page mode", 16'(wt), 16'h0);
      end
      edge_sample();
      chk("R5", "valid after delay", 16'(valid), 16'h1);
      chk("R9", "page word", dq, VEC_EXP[i]);
    end

    // word select within a page (R6)
    edge_drive();
    ce_ni = 1'b1;
    edge_drive();
    ce_ni = 1'b0; adv_ni = 1'b0; addr = 6'd8;
    repeat (ACC_LAT) edge_sample();
    chk("R6", "first word", dq, word_at(8));
    for (int w = 1; w < 4; w++) begin
      addr = 6'(8 + w);
      #1;
      chk("R6", "word select", dq, word_at(8 + w));
      chk("R6", "valid kept", 16'(valid), 16'h1);
    end

    // page latch on adv_ni high (R7)
    edge_drive();
    adv_ni = 1'b1;
    edge_drive();
    addr = 6'd21;
    #3;
    chk("R7", "held page", dq, word_at(9));
    edge_sample();
    chk("R7", "held page after edge", dq, word_at(9));
    chk("R7", "held page valid", 16'(valid), 16'h1);
    #1 adv_ni = 1'b0;
    #1;
    chk("R5", "miss drops valid", 16'(valid), 16'h0);
    repeat (ACC_LAT) edge_sample();
    chk("R7", "new page word", dq, word_at(21));

    // write enable blocks reads (R3)
    we_ni = 1'b0;
    #1;
    chk("R3", "oe with we low", 16'(dq_oe), 16'h0);
    chk("R3", "valid with we low", 16'(valid), 16'h0);
    chk("R3", "dq with we low", dq, 16'h0);
    edge_drive();
    we_ni = 1'b1; ce_ni = 1'b1; adv_ni = 1'b1;

    // burst mode (R2, R8)
    cfg_wr = 1'b1; cfg_async = 1'b0;
    edge_drive();
    cfg_wr = 1'b0;
    ce_ni = 1'b0; adv_ni = 1'b0; addr = 6'd62;
    edge_drive();
    adv_ni = 1'b1;
    #3;
    chk("R8", "wait in latency 1", 16'(wt), 16'h1);
    chk("R8", "valid in latency 1", 16'(valid), 16'h0);
    edge_sample();
    chk("R8", "wait in latency 2", 16'(wt), 16'h1);
    edge_sample();
    chk("R8", "wait after latency", 16'(wt), 16'h0);
    chk("R8", "valid after latency", 16'(valid), 16'h1);
    chk("R8", "burst word 0", dq, word_at(62));
    for (int k = 1; k < 4; k++) begin
      edge_sample();
      chk("R8", "burst next word", dq, word_at((62 + k) % 64));
    end

    // burst restart (R10)
    #1 adv_ni = 1'b0; addr = 6'd4;
    edge_drive();
    adv_ni = 1'b1;
    #3;
    chk("R10", "restart wait", 16'(wt), 16'h1);
    chk("R10", "restart valid", 16'(valid), 16'h0);
    edge_sample();
    edge_sample();
    chk("R10", "restart word", dq, word_at(4));

    // mode write aborts, back to page mode (R2)
    #1 cfg_wr = 1'b1; cfg_async = 1'b1;
    edge_drive();
    cfg_wr = 1'b0;
    #3;
    chk("R2", "valid after mode write", 16'(valid), 16'h0);
    chk("R2", "wait after mode write", 16'(wt), 16'h0);
    repeat (ACC_LAT) edge_sample();
    chk("R2", "page mode word", dq, word_at(4));
    chk("R4", "no wait in page mode", 16'(wt), 16'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule